// File: doc/BRIEF.md
# Camera Control Bus Single-Register Master

This block is the master side of a two-wire serial control bus of the kind used to configure image sensors. A host raises a one-cycle request with a direction select, an 8-bit register sub-address and, for writes, one data byte. The block then drives the bus clock and the open-drain data line until the transfer is finished. It ends with a one-cycle done pulse. After a read, the received byte is on the read-data output in that cycle. Every transfer moves exactly one register byte. The ninth bit after each byte the master sends is released and never looked at, so a silent slave and an acknowledging slave give the same result.

A write is one bus frame. A read is two frames: a first frame that sends the sub-address and is closed by a full stop, then a second frame that opens with a new start, carries the read identifier, takes one byte from the slave and closes it with a not-acknowledge. Bit timing comes from a quarter-bit tick. The system clock is divided by DIV = CLK_HZ / (4 * BUS_HZ). Each bus bit lasts four ticks: clock low, high, high, low. Data changes only in the first quarter, while the clock is low. Read bits are sampled at the tick between the two high quarters.

The sequencer has five states:
- IDLE waits for a request. A request in IDLE moves it to START.
- START makes one start slot, then moves to XFER.
- XFER sends or receives one 9-bit byte slot per phase. Its phases are: write identifier, sub-address, write data, read identifier, read byte. At the end of the sub-address phase it moves to STOP for a read. At the end of the data phase or the read-byte phase it also moves to STOP.
- STOP makes one stop slot. It moves to GAP after the first frame of a read, and to IDLE with done otherwise.
- GAP holds the bus free for one slot, then returns to START with the read-identifier phase selected.

The first quarter of a START slot may be shorter than a full quarter, because the tick runs freely. The bus lines are still both high during that quarter.

Top module: `camctl_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the bus clock is high, the data line is released (reads high through the pull-up), and done is low.
- R2: A write produces, most significant bit first, exactly: start, the byte {DEV_ID[6:0], 0}, the sub-address, the write data, stop.
- R3: A read produces exactly: start, {DEV_ID[6:0], 0}, sub-address, stop, start, {DEV_ID[6:0], 1}, one byte from the slave, stop. There is no start without a stop before it.
- R4: The ninth bit after each byte the master sends is released by the master. Whether the slave pulls it low or not changes neither the frame nor its completion.
- R5: The ninth bit after the read byte is a not-acknowledge: the line is high while the bus clock is high.
- R6: rd_data shows the received byte, first-received bit in bit 7, in the done cycle of a read. A later write leaves rd_data unchanged.
- R7: done is high for exactly one system clock, after the final stop of the transfer has appeared on the bus.
- R8: While the bus clock is high, the data line changes only to make a start (falling) or a stop (rising).
- R9: A request while a transfer is in progress is ignored. Direction, sub-address and write data are captured at acceptance, so later changes to those inputs have no effect on the transfer.
- R10: Within a byte, successive rising edges of the bus clock are 4*DIV system clocks apart, where DIV = CLK_HZ / (4 * BUS_HZ).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle transfer request, taken only when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| sub_addr | input | 8 | Register sub-address |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read, valid in the done cycle of a read |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| bus_clk | output | 1 | Bus clock, idles high |
| bus_data | inout | 1 | Open-drain bus data: driven low or released |

## Verification
The bench places a slave model on the wires. It decodes starts, stops and 9-bit bytes, and a scoreboard compares them with the frames that the driver predicts.

The corner cases it targets, and how a wrong design would show up:
- The read-frame split. A design that used a repeated start would lose the stop item and fail the scoreboard.
- The slave's acknowledge, sent on some transfers and withheld on others. A design that waited for it would hang or change the frame.
- The closing not-acknowledge. A design that drove an acknowledge would show a low ninth bit.
- A request arriving mid-transfer, with the operand inputs changed just after acceptance. A design that re-armed, or that used live inputs, would emit an extra frame or wrong bytes.

The bench also measures the bus clock spacing, and checks that rd_data survives a following write.

// File: rtl/camctl_pkg.sv
package camctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_XFER,
        ST_STOP,
        ST_GAP
    } ctl_state_t;

    typedef enum logic [2:0] {
        PH_ID_W,
        PH_SUB,
        PH_DATA,
        PH_ID_R,
        PH_READ
    } ctl_phase_t;
endpackage

// File: rtl/camctl_tick.sv
module camctl_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/camctl_rxshift.sv
module camctl_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (shift_en)
            value <= {value[W-2:0], bit_in};
    end
endmodule

// File: rtl/camctl_pins.sv
module camctl_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_d,
    input  logic rel_d,
    output logic scl_q,
    output logic rel_q
);
    // Registered pin levels, so the bus lines never carry decode glitches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            rel_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            rel_q <= rel_d;
        end
    end
endmodule

// File: rtl/camctl_master.sv
module camctl_master
    import camctl_pkg::*;
#(
    parameter int          CLK_HZ = 50_000_000,
    parameter int          BUS_HZ = 100_000,
    parameter logic [6:0]  DEV_ID = 7'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       rd_nwr,
    input  logic [7:0] sub_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       bus_clk,
    inout  wire        bus_data
);
    localparam int DIV_RAW = CLK_HZ / (4 * BUS_HZ);
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int BW      = 8;

    ctl_state_t st_q, st_d;
    ctl_phase_t ph_q, ph_d;
    logic [1:0] qtr_q, qtr_d;
    logic [3:0] bit_q, bit_d;
    logic       sec_q, sec_d;
    logic       rd_q;
    logic [BW-1:0] sub_q, wdat_q, rdat_q, rx_val, tx_byte;
    logic       done_q, load, fin, tick, slot_end, sample_en;
    logic       scl_d, rel_d, scl_o, rel_o, tx_bit;

    camctl_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    camctl_rxshift #(.W(BW)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(sample_en),
        .bit_in(bus_data), .value(rx_val)
    );

    camctl_pins u_pins (
        .clk(clk), .rst_n(rst_n), .scl_d(scl_d), .rel_d(rel_d),
        .scl_q(scl_o), .rel_q(rel_o)
    );

    assign bus_clk  = scl_o;
    assign bus_data = rel_o ? 1'bz : 1'b0;
    assign done     = done_q;
    assign rd_data  = rdat_q;

    assign slot_end  = tick && (qtr_q == 2'd3);
    // Middle of the high part of the bus clock: the tick that ends quarter 1.
    assign sample_en = tick && (st_q == ST_XFER) && (ph_q == PH_READ)
                       && (qtr_q == 2'd1) && (bit_q < 4'd8);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ph_q  <= PH_ID_W;
            qtr_q <= 2'd0;
            bit_q <= 4'd0;
            sec_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            qtr_q <= qtr_d;
            bit_q <= bit_d;
            sec_q <= sec_d;
        end
    end

    // Operand capture, done and read result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            sub_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (load) begin
                rd_q   <= rd_nwr;
                sub_q  <= sub_addr;
                wdat_q <= wr_data;
            end
            if (fin && rd_q)
                rdat_q <= rx_val;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        ph_d  = ph_q;
        qtr_d = qtr_q;
        bit_d = bit_q;
        sec_d = sec_q;
        load  = 1'b0;
        fin   = 1'b0;
        if (st_q != ST_IDLE && tick)
            qtr_d = qtr_q + 2'd1;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_d  = ST_START;
                    ph_d  = PH_ID_W;
                    qtr_d = 2'd0;
                    bit_d = 4'd0;
                    sec_d = 1'b0;
                    load  = 1'b1;
                end
            end
            ST_START: begin
                if (slot_end) begin
                    st_d  = ST_XFER;
                    bit_d = 4'd0;
                end
            end
            ST_XFER: begin
                if (slot_end) begin
                    if (bit_q == 4'd8) begin
                        bit_d = 4'd0;
                        unique case (ph_q)
                            PH_ID_W: ph_d = PH_SUB;
                            PH_SUB: begin
                                if (rd_q) st_d = ST_STOP;
                                else      ph_d = PH_DATA;
                            end
                            PH_DATA: st_d = ST_STOP;
                            PH_ID_R: ph_d = PH_READ;
                            PH_READ: st_d = ST_STOP;
                        endcase
                    end else begin
                        bit_d = bit_q + 4'd1;
                    end
                end
            end
            ST_STOP: begin
                if (slot_end) begin
                    if (rd_q && !sec_q) begin
                        st_d  = ST_GAP;
                        sec_d = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                        fin  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (slot_end) begin
                    st_d = ST_START;
                    ph_d = PH_ID_R;
                end
            end
        endcase
    end

    // Byte on the wire for the current phase
    always_comb begin
        case (ph_q)
            PH_ID_W: tx_byte = {DEV_ID, 1'b0};
            PH_SUB:  tx_byte = sub_q;
            PH_DATA: tx_byte = wdat_q;
            PH_ID_R: tx_byte = {DEV_ID, 1'b1};
            default: tx_byte = '1;
        endcase
    end

    // Ninth bits and every read bit leave the line released.
    assign tx_bit = (bit_q == 4'd8) ? 1'b1 : tx_byte[3'd7 - bit_q[2:0]];

    // Output decode per quarter
    always_comb begin
        scl_d = 1'b1;
        rel_d = 1'b1;
        unique case (st_q)
            ST_IDLE, ST_GAP: begin
                scl_d = 1'b1;
                rel_d = 1'b1;
            end
            ST_START: begin
                scl_d = (qtr_q != 2'd3);
                rel_d = (qtr_q < 2'd2);
            end
            ST_XFER: begin
                scl_d = (qtr_q == 2'd1) || (qtr_q == 2'd2);
                rel_d = tx_bit;
            end
            ST_STOP: begin
                scl_d = (qtr_q != 2'd0);
                rel_d = (qtr_q >= 2'd2);
            end
        endcase
    end

    // R1: lines idle while the sequencer rests
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> (scl_o && rel_o && !done_q));

    // R3: a start slot is entered only from idle or from the post-stop gap
    a_r3_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_START && $past(st_q) != ST_START)
            |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_GAP));

    // R5: the ninth bit of the read byte leaves the line released
    a_r5_na_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && $past(st_q) == ST_XFER && ph_q == PH_READ) |-> rel_o);

    // R7: done lasts one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: no data change on the wire during clock-high inside a byte
    a_r8_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && $past(st_q) == ST_XFER && scl_o && $past(scl_o))
            |-> $stable(rel_o));

    // R9: captured operands hold for the whole transfer
    a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(sub_q) && $stable(wdat_q) && $stable(rd_q)));
endmodule

// File: tb/test_camctl_master.sv
`timescale 1ns/1ps
module test_camctl_master;
    localparam int CLK_HZ = 8_000_000;
    localparam int BUS_HZ = 400_000;
    localparam int DIV    = CLK_HZ / (4 * BUS_HZ);
    localparam logic [6:0] DEV = 7'h21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, rd_nwr = 1'b0;
    logic [7:0] sub_addr = 8'h00, wr_data = 8'h00;
    wire  [7:0] rd_data;
    wire  done, bus_clk;
    wire  bus_data;
    logic slv_low = 1'b0;

    pullup (bus_data);
    assign bus_data = slv_low ? 1'b0 : 1'bz;

    camctl_master #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .DEV_ID(DEV)) i_camctl_master (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr),
        .sub_addr(sub_addr), .wr_data(wr_data), .rd_data(rd_data),
        .done(done), .bus_clk(bus_clk), .bus_data(bus_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    int total = 0, bad = 0;
    bit finished = 1'b0;
    string cur_tag = "R2";
    logic [11:0] exp_q[$];   // {kind[1:0], care9, ninth, byte}

    // Slave model state
    int bitcnt = 0, bytecnt = 0, start_cnt = 0;
    logic [7:0] shreg = 8'h00, slv_val = 8'h00;
    logic rd_mode = 1'b0, ack_en = 1'b0;
    time last_pos = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic [1:0] k, input logic care,
                                       input logic nin, input logic [7:0] b);
        return {k, care, nin, b};
    endfunction

    // Scoreboard monitor side: compare each bus item with the oldest prediction.
    task automatic observe(input logic [11:0] got);
        logic [11:0] e;
        bit ok;
        if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected bus item", int'(got), 0);
        end else begin
            e = exp_q.pop_front();
            ok = (got[11:10] == e[11:10]) && (got[7:0] == e[7:0]) && (!e[9] || got[8] == e[8]);
            check(ok, e[9] ? "R5" : cur_tag, int'(got), int'(e));
        end
    endtask

    // Start: data falls with clock high. Stop: data rises with clock high.
    // Any other such edge shows up as an extra item (R8).
    always @(negedge bus_data) begin
        if (rst_n === 1'b1 && bus_clk === 1'b1) begin
            start_cnt++;
            bitcnt = 0;
            bytecnt = 0;
            rd_mode = 1'b0;
            observe(mk(2'd0, 1'b0, 1'b0, 8'h00));
        end
    end

    always @(posedge bus_data) begin
        if (rst_n === 1'b1 && bus_clk === 1'b1)
            observe(mk(2'd1, 1'b0, 1'b0, 8'h00));
    end

    always @(posedge bus_clk) begin
        if (rst_n === 1'b1) begin
            if (bitcnt < 8) begin
                shreg = {shreg[6:0], bus_data};
                if (bitcnt == 2 && bytecnt == 0)   // R10 bus clock spacing
                    check(($time - last_pos) == 4 * DIV * 8, "R10",
                          int'($time - last_pos), 4 * DIV * 8);
                if (bitcnt == 7 && bytecnt == 0 && bus_data === 1'b1)
                    rd_mode = 1'b1;
                bitcnt++;
            end else begin
                observe(mk(2'd2, 1'b0, bus_data, shreg));
                bytecnt++;
                bitcnt = 0;
            end
            last_pos = $time;
        end
    end

    always @(negedge bus_clk) begin
        if (rst_n === 1'b1) begin
            if (rd_mode && bytecnt == 1 && bitcnt < 8)
                slv_low = ~slv_val[7 - bitcnt];
            else if (!(rd_mode && bytecnt == 1) && bitcnt == 8)
                slv_low = ack_en;
            else
                slv_low = 1'b0;
        end
    end

    task automatic issue(input logic rd, input logic [7:0] s, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; rd_nwr = rd; sub_addr = s; wr_data = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(output logic [7:0] rv);
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, "R7 done seen", int'(done), 1);
        check(exp_q.size() == 0, "R7 done after final stop", exp_q.size(), 0);
        rv = rd_data;
        @(negedge clk);
        check(done === 1'b0, "R7 done width", int'(done), 0);
        repeat (3) @(negedge clk);
        check(bus_clk === 1'b1 && bus_data === 1'b1, "R1 idle after transfer",
              int'({bus_clk, bus_data}), 3);
    endtask

    task automatic push_write(input logic [7:0] s, input logic [7:0] d);
        exp_q.push_back(mk(2'd0, 1'b0, 1'b0, 8'h00));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, {DEV, 1'b0}));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, s));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, d));
        exp_q.push_back(mk(2'd1, 1'b0, 1'b0, 8'h00));
    endtask

    task automatic run_write(input logic [7:0] s, input logic [7:0] d,
                             input logic ack, input string tag);
        logic [7:0] rv;
        cur_tag = tag; ack_en = ack;
        push_write(s, d);
        issue(1'b0, s, d);
        wait_done(rv);
    endtask

    task automatic run_read(input logic [7:0] s, input logic [7:0] v,
                            input logic ack, input string tag);
        logic [7:0] rv;
        cur_tag = tag; ack_en = ack; slv_val = v;
        exp_q.push_back(mk(2'd0, 1'b0, 1'b0, 8'h00));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, {DEV, 1'b0}));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, s));
        exp_q.push_back(mk(2'd1, 1'b0, 1'b0, 8'h00));
        exp_q.push_back(mk(2'd0, 1'b0, 1'b0, 8'h00));
        exp_q.push_back(mk(2'd2, 1'b0, 1'b0, {DEV, 1'b1}));
        exp_q.push_back(mk(2'd2, 1'b1, 1'b1, v));   // R5: NA high
        exp_q.push_back(mk(2'd1, 1'b0, 1'b0, 8'h00));
        issue(1'b1, s, 8'h00);
        wait_done(rv);
        check(rv == v, "R6 read data", int'(rv), int'(v));
    endtask

    initial begin
        int sc;
        logic [7:0] rv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_clk === 1'b1, "R1 clock idle", int'(bus_clk), 1);
        check(bus_data === 1'b1, "R1 data released", int'(bus_data), 1);
        check(done === 1'b0, "R1 done low", int'(done), 0);

        run_write(8'h12, 8'hA5, 1'b1, "R2");
        run_write(8'hFF, 8'h00, 1'b0, "R4");
        run_read(8'h3C, 8'h96, 1'b1, "R3");
        run_read(8'h80, 8'h01, 1'b0, "R4");
        run_write(8'h55, 8'h6B, 1'b1, "R2");
        check(rd_data == 8'h01, "R6 held across write", int'(rd_data), 1);

        // R9: busy request ignored, inputs changed after acceptance
        cur_tag = "R9"; ack_en = 1'b1;
        sc = start_cnt;
        push_write(8'h5A, 8'hC3);
        issue(1'b0, 8'h5A, 8'hC3);
        sub_addr = 8'h00; wr_data = 8'hFF; rd_nwr = 1'b1;
        repeat (100) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_done(rv);
        repeat (1500) @(negedge clk);
        check(start_cnt - sc == 1, "R9 single frame", start_cnt - sc, 1);
        check(exp_q.size() == 0, "R9 no extra items", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule